// File: doc/BRIEF.md
# SPI Master with Programmable Select Timing

This block is a single-channel SPI master that moves one 8-bit frame per start command. Software, or a local controller, programs it through a small byte-wide register port. The programmable items are:

- the serial clock rate;
- the wait between pulling the active-low select low and the first clock edge;
- the wait between the last clock edge and releasing select;
- the minimum time select stays released before another frame may begin.

Writing the data register starts a frame. When select is released, the byte captured from the serial input appears in a read register and a sticky done flag is raised. The serial clock idles low. MOSI changes on falling edges and MISO is captured on rising edges, most significant bit first.

Two control bits shape the data path. One sets the level MOSI holds whenever no frame bit is being driven. The other routes MOSI back to the receive shifter in place of the MISO pin. The engine must be disabled while the timing registers are changed. Clearing the enable bit during a frame abandons the frame at once.

Top module: `spi_sel_master`

## Requirements
- R1: After reset, select is high, the serial clock is low, MOSI is 1, and the status register (address 6: bit 0 busy, bit 1 done) reads 0. The control register (address 0) resets to 0x04: bit 0 enable, bit 1 loop-back, bit 2 idle level.
- R2: With divisor D in address 1, every high and every low half of the serial clock lasts D+1 bus clocks, so D=0 gives half the bus rate.
- R3: With value A in address 2, the first rising clock edge comes (A+1)·2·(D+1) bus clocks after select goes low. The clock stays low while select is high.
- R4: With value B in address 3, select goes high (B+1)·2·(D+1) bus clocks after the eighth falling clock edge.
- R5: With value G in address 4, busy stays set for (G+1)·2·(D+1)+2 bus clocks after select goes high, and only then does it clear.
- R6: Exactly eight rising edges occur per frame. MOSI carries the written byte MSB first and is valid at each rising edge. The byte sampled from MISO at those edges is read back from address 5.
- R7: MOSI equals control bit 2 whenever select is high, and also between the last falling edge and select release.
- R8: With control bit 1 set, the received byte equals the transmitted byte and the MISO pin has no effect.
- R9: A write to address 5 while busy or while disabled starts nothing and does not change the frame in progress. Writes to addresses 1–4 while busy are ignored.
- R10: Done sets when select goes high, stays set until address 5 is read, and that read clears it.
- R11: Writing the control register with bit 0 clear during a frame makes select high, the clock low and busy clear on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done on data read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong phase counter or a wrong length computation in the sequencer shows first on the select and clock pins. The select-to-clock, half-period and clock-to-release intervals each move by whole bus clocks, and the bench measures each interval inside the same frame. A wrong state in the gap phase shows as busy clearing early or late in the status register, within that frame's next-access window. Shift-register or bit-order faults appear on MOSI at the first rising edge that carries a wrong bit, and in the received byte as soon as the frame ends.

// File: rtl/spi_sel_master.sv
module spi_sel_master #(
  parameter int RW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_ss_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int CW = 2*RW + 3;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG, S_GAP} state_t;

  state_t          state;
  logic            en_r, loop_r, idle_r;
  logic [RW-1:0]   div_r, lead_r, lag_r, gap_r;
  logic [RW-1:0]   hcnt;
  logic [CW-1:0]   cnt;
  logic [3:0]      ph;
  logic [7:0]      tx_sh, rx_sh, rx_data;
  logic            done_r, sclk_r, ss_r;

  logic            busy, wr_ctrl, wr_cfg, start, rd_data, abort, miso_eff;
  logic [CW-1:0]   half_len, lead_len, lag_len, gap_len;

  assign busy     = (state != S_IDLE);
  assign wr_ctrl  = reg_wr && (reg_addr == 3'd0);
  assign wr_cfg   = reg_wr && !busy;
  assign start    = reg_wr && (reg_addr == 3'd5) && en_r && !busy;
  assign rd_data  = reg_rd && (reg_addr == 3'd5);
  assign abort    = wr_ctrl && !reg_wdata[0] && busy;

  assign half_len = CW'(div_r) + CW'(1);
  assign lead_len = (CW'(lead_r) + CW'(1)) * half_len * CW'(2);
  assign lag_len  = (CW'(lag_r)  + CW'(1)) * half_len * CW'(2);
  assign gap_len  = (CW'(gap_r)  + CW'(1)) * half_len * CW'(2) + CW'(2);

  assign spi_mosi = (state == S_LEAD || state == S_SHIFT) ? tx_sh[7] : idle_r;
  assign miso_eff = loop_r ? spi_mosi : spi_miso;
  assign spi_sclk = sclk_r;
  assign spi_ss_n = ss_r;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {5'd0, idle_r, loop_r, en_r};
      3'd1:    reg_rdata = 8'(div_r);
      3'd2:    reg_rdata = 8'(lead_r);
      3'd3:    reg_rdata = 8'(lag_r);
      3'd4:    reg_rdata = 8'(gap_r);
      3'd5:    reg_rdata = rx_data;
      3'd6:    reg_rdata = {6'd0, done_r, busy};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      loop_r <= 1'b0;
      idle_r <= 1'b1;
      div_r  <= '0;
      lead_r <= '0;
      lag_r  <= '0;
      gap_r  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_r   <= reg_wdata[0];
        loop_r <= reg_wdata[1];
        idle_r <= reg_wdata[2];
      end
      if (wr_cfg && reg_addr == 3'd1) div_r  <= reg_wdata[RW-1:0];
      if (wr_cfg && reg_addr == 3'd2) lead_r <= reg_wdata[RW-1:0];
      if (wr_cfg && reg_addr == 3'd3) lag_r  <= reg_wdata[RW-1:0];
      if (wr_cfg && reg_addr == 3'd4) gap_r  <= reg_wdata[RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      hcnt    <= '0;
      ph      <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      done_r  <= 1'b0;
      sclk_r  <= 1'b0;
      ss_r    <= 1'b1;
    end else begin
      if (rd_data) done_r <= 1'b0;
      if (abort) begin
        state  <= S_IDLE;
        sclk_r <= 1'b0;
        ss_r   <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state <= S_LEAD;
            ss_r  <= 1'b0;
            tx_sh <= reg_wdata;
            cnt   <= '0;
          end
          S_LEAD: begin
            if (cnt == lead_len - CW'(1)) begin
              state  <= S_SHIFT;
              sclk_r <= 1'b1;
              rx_sh  <= {rx_sh[6:0], miso_eff};
              ph     <= '0;
              hcnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          S_SHIFT: begin
            if (hcnt == div_r) begin
              hcnt <= '0;
              if (!ph[0]) begin
                sclk_r <= 1'b0;
                tx_sh  <= {tx_sh[6:0], 1'b0};
                if (ph == 4'd14) begin
                  state <= S_LAG;
                  cnt   <= '0;
                end else begin
                  ph <= ph + 4'd1;
                end
              end else begin
                sclk_r <= 1'b1;
                rx_sh  <= {rx_sh[6:0], miso_eff};
                ph     <= ph + 4'd1;
              end
            end else begin
              hcnt <= hcnt + RW'(1);
            end
          end
          S_LAG: begin
            if (cnt == lag_len - CW'(1)) begin
              state   <= S_GAP;
              ss_r    <= 1'b1;
              cnt     <= '0;
              done_r  <= 1'b1;
              rx_data <= rx_sh;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          S_GAP: begin
            if (cnt == gap_len - CW'(1)) state <= S_IDLE;
            else cnt <= cnt + CW'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_sel_master_chk.sv
module spi_sel_master_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n,
  input logic          sclk,
  input logic          mosi,
  input logic          idle_lvl,
  input logic          en,
  input logic          busy,
  input logic          done,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [RW-1:0] div
);
  assert_clock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);

  assert_select_leads_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (!ss_n && !$past(ss_n)));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (mosi == idle_lvl));

  assert_gap_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ss_n) && en) |-> busy);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_rd && reg_addr == 3'd5)) |=> done);

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd1) |=> $stable(div));
endmodule

bind spi_sel_master spi_sel_master_chk #(.RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ss_n(spi_ss_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .idle_lvl(idle_r), .en(en_r), .busy(busy), .done(done_r),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .div(div_r)
);

// File: tb/spi_sel_master_tb.sv
module spi_sel_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic sclk, ss_n, mosi, miso;

  int total = 0, bad = 0;
  int cyc = 0, exp_half = 1;
  int t_ssf, t_rise0, t_lastfall, t_ssr, t_bend, t_edge;
  int nrise = 0, nfall = 0, hp_err = 0, lag_err = 0;
  logic [7:0] mosi_bits, slv_byte = 8'h00;
  logic p_ss = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;

  always #2 clk = ~clk;

  spi_sel_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk), .spi_ss_n(ss_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  assign miso = slv_byte[7 - ((nrise > 7) ? 7 : nrise)];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (p_ss && !ss_n) begin t_ssf = cyc; nrise = 0; nfall = 0; end
    if (!p_sclk && sclk) begin
      if (nrise == 0) t_rise0 = cyc;
      else if (cyc - t_edge != exp_half) hp_err++;
      if (nrise < 8) mosi_bits[7 - nrise] = mosi;
      nrise++;
      t_edge = cyc;
    end
    if (p_sclk && !sclk) begin
      if (cyc - t_edge != exp_half) hp_err++;
      t_edge = cyc; t_lastfall = cyc; nfall++;
    end
    if (!ss_n && nfall == 8 && mosi != dut_i.idle_r) lag_err++;
    if (!p_ss && ss_n) t_ssr = cyc;
    if (reg_addr == 3'd6 && p_busy && !reg_rdata[0]) t_bend = cyc;
    p_ss = ss_n; p_sclk = sclk; p_busy = (reg_addr == 3'd6) ? reg_rdata[0] : p_busy;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic cfg(input int n, input int ld, input int lg, input int gp, input bit lb, input bit idl);
    wr(3'd0, {5'd0, idl, lb, 1'b0});
    wr(3'd1, 8'(n)); wr(3'd2, 8'(ld)); wr(3'd3, 8'(lg)); wr(3'd4, 8'(gp));
    wr(3'd0, {5'd0, idl, lb, 1'b1});
    exp_half = n + 1; hp_err = 0; lag_err = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk); reg_addr = 3'd6;
    for (int i = 0; i < 5000 && (reg_rdata[0] !== 1'b0 || p_busy); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_frame(input int n, input int ld, input int lg, input int gp,
                              input logic [7:0] tx, input logic [7:0] exp_rx);
    logic [7:0] v;
    int h2;
    h2 = 2 * (n + 1);
    wait_idle();
    chk(t_rise0 - t_ssf == (ld + 1) * h2, "R3 lead", t_rise0 - t_ssf, (ld + 1) * h2);
    chk(hp_err == 0, "R2 half period", hp_err, 0);
    chk(nrise == 8, "R6 edge count", nrise, 8);
    chk(t_ssr - t_lastfall == (lg + 1) * h2, "R4 lag", t_ssr - t_lastfall, (lg + 1) * h2);
    chk(t_bend - t_ssr == (gp + 1) * h2 + 2, "R5 gap", t_bend - t_ssr, (gp + 1) * h2 + 2);
    chk(mosi_bits == tx, "R6 mosi bits", mosi_bits, tx);
    chk(lag_err == 0, "R7 lag idle level", lag_err, 0);
    rd(3'd6, v);
    chk(v == 8'h02, "R10 done set", v, 2);
    rd(3'd5, v);
    chk(v == exp_rx, "R6/R8 rx byte", v, exp_rx);
    rd(3'd6, v);
    chk(v == 8'h00, "R10 done cleared", v, 0);
  endtask

  task automatic frame(input int n, input int ld, input int lg, input int gp, input bit lb,
                       input bit idl, input logic [7:0] tx, input logic [7:0] sb);
    logic [7:0] v;
    cfg(n, ld, lg, gp, lb, idl);
    @(negedge clk);
    chk(mosi == idl, "R7 idle level", mosi, idl);
    slv_byte = sb;
    wr(3'd5, tx);
    rd(3'd6, v);
    chk(v[1] == 1'b0, "R10 done clear at start", v[1], 0);
    finish_frame(n, ld, lg, gp, tx, lb ? tx : sb);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b1, "R1 pins", {ss_n, sclk, mosi}, 3'b101);
    rd(3'd6, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(3'd0, v); chk(v == 8'h04, "R1 control", v, 4);

    frame(0, 0, 0, 0, 1'b0, 1'b1, 8'hA5, 8'h3C);
    frame(2, 1, 3, 2, 1'b0, 1'b0, 8'h81, 8'hFF);
    frame(1, 0, 0, 0, 1'b1, 1'b1, 8'h5E, 8'h00);

    for (int k = 0; k < 8; k++) begin
      int n, ld, lg, gp;
      logic [7:0] tx, sb;
      bit lb, idl;
      n = $urandom_range(3, 0); ld = $urandom_range(3, 0);
      lg = $urandom_range(3, 0); gp = $urandom_range(3, 0);
      tx = 8'($urandom); sb = 8'($urandom);
      lb = 1'($urandom); idl = 1'($urandom);
      frame(n, ld, lg, gp, lb, idl, tx, sb);
    end

    cfg(1, 1, 1, 1, 1'b0, 1'b1);
    slv_byte = 8'h96;
    wr(3'd5, 8'hC3);
    repeat (6) @(negedge clk);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h07);
    finish_frame(1, 1, 1, 1, 8'hC3, 8'h96);
    rd(3'd1, v); chk(v == 8'h01, "R9 cfg ignored while busy", v, 1);

    wr(3'd0, 8'h04);
    wr(3'd5, 8'h77);
    begin
      int seen;
      seen = 0;
      reg_addr = 3'd6;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!ss_n || reg_rdata[0]) seen++;
      end
      chk(seen == 0, "R9 disabled write ignored", seen, 0);
    end

    cfg(2, 3, 0, 0, 1'b0, 1'b1);
    wr(3'd5, 8'hF0);
    repeat (30) @(negedge clk);
    chk(ss_n == 1'b0 && sclk == 1'b1, "R11 mid-frame setup", {ss_n, sclk}, 2'b01);
    @(negedge clk); reg_addr = 3'd0; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 3'd6; #1;
    chk(ss_n == 1'b1 && sclk == 1'b0 && reg_rdata[0] == 1'b0, "R11 abort",
        {ss_n, sclk, reg_rdata[0]}, 3'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule